// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This unit sits between an in-order decoder that presents up to two decoded instructions per cycle and the register-access stages of four execution pipes: a complex integer pipe (I), a simple integer pipe (J), a load/store pipe (L) and a floating-point pipe (F). Each slot carries a valid bit, a three-bit class tag and a payload word. The unit picks a pipe, or a set of pipes, for each instruction. It enforces the class restrictions and resolves structural conflicts between the two slots and against pipes that are still occupied. It reports per slot whether the instruction was taken in this cycle.

Acceptance is combinational: `slot0Ready` and `slot1Ready` say in the same cycle which slots were taken. The decoder must hold any slot that was not taken. When slot 0 is taken and slot 1 is not, the decoder moves the old slot-1 instruction into slot 0. The dispatch valids, the source slot for each pipe and the per-pipe payload lanes are registered and appear one cycle after acceptance. A per-pipe busy input stands in for operand readiness and downstream occupancy.

Top module: `steer_unit`

## Requirements
- R1: In any cycle each pipe is granted to at most one slot, so at most two instructions are dispatched per cycle.
- R2: A simple-class instruction (code 0) goes to I when I is free, otherwise to J. When both slots hold code 0 and nothing is busy, slot 0 takes I and slot 1 takes J.
- R3: Complex-class instructions (code 1) and the unassigned codes 6 and 7 may use only the I pipe.
- R4: A memory-class instruction (code 2) uses only L, and a float-class instruction (code 3) uses only F.
- R5: A reservation-class instruction (code 4) is taken only from slot 0 and claims L and I together in one cycle. In slot 1 it is never taken.
- R6: A synchronize-class instruction (code 5) claims I, L and F together in one cycle.
- R7: When both slots need the same pipe, slot 0 gets it and slot 1 is not taken.
- R8: Slot 1 is taken only in a cycle in which slot 0 is valid and taken.
- R9: A pipe whose busy bit is set (bit 0 = I, bit 1 = J, bit 2 = L, bit 3 = F) receives no dispatch. An instruction that cannot get all its pipes is not taken.
- R10: `dispValid`, `dispSlot` and the payload lanes reflect the cycle's grants one clock later. Lane p (bits p*DATA_W upward) carries the granted slot's payload, and it is zero when pipe p was not dispatched. `dispSlot[p]` is 1 when slot 1 fed pipe p.
- R11: A synchronous active-high reset clears all dispatch valids, source bits and lanes.
- R12: `stall` is high exactly when a valid slot is not taken in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0Valid | input | 1 | Slot 0 holds an instruction |
| slot0Class | input | 3 | Slot 0 class tag |
| slot0Data | input | DATA_W | Slot 0 payload |
| slot1Valid | input | 1 | Slot 1 holds an instruction |
| slot1Class | input | 3 | Slot 1 class tag |
| slot1Data | input | DATA_W | Slot 1 payload |
| pipeBusy | input | 4 | Per-pipe occupied flags (I, J, L, F from bit 0) |
| slot0Ready | output | 1 | Slot 0 taken this cycle |
| slot1Ready | output | 1 | Slot 1 taken this cycle |
| stall | output | 1 | A valid slot was left waiting |
| dispValid | output | 4 | Registered per-pipe dispatch valid |
| dispSlot | output | 4 | Registered per-pipe source slot |
| laneData | output | 4*DATA_W | Registered per-pipe payload lanes |

## Verification
The hard cases are cycles where slot 0 takes a pipe and, in the same cycle, slot 1 is refused because of that choice. Examples are a simple op in slot 0 that takes I while slot 1 holds an I-only op, a reservation op that takes both L and I while slot 1 still fits into J, and a synchronize op that leaves only J. The vector table places these pairs in both slot orders and combines them with busy masks. It compares the same-cycle ready and stall values, and then the registered valids, source bits and lane payloads after the next edge, against values derived from the class rules. A directed sequence then shows that a refused slot-1 instruction dispatches once it reaches slot 0.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int PIPE_CNT = 4;
  localparam int SLOT_CNT = 2;
  localparam int CLASS_W  = 3;
  localparam int PIPE_I   = 0;
  localparam int PIPE_J   = 1;
  localparam int PIPE_L   = 2;
  localparam int PIPE_F   = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_SIMPLE  = 3'd0,
    CLS_COMPLEX = 3'd1,
    CLS_MEM     = 3'd2,
    CLS_FLOAT   = 3'd3,
    CLS_RESERVE = 3'd4,
    CLS_SYNC    = 3'd5,
    CLS_SPARE6  = 3'd6,
    CLS_SPARE7  = 3'd7
  } instClass_e;

  typedef logic [PIPE_CNT-1:0] pipeMask_t;

  // strobes from control to the lane registers
  typedef struct packed {
    pipeMask_t grant0;
    pipeMask_t grant1;
    logic      take0;
    logic      take1;
  } steerStrobe_t;
endpackage

// File: rtl/steer_pick.sv
module steer_pick
  import steer_pkg::*;
#(
  parameter int SLOT_IDX = 0
) (
  input  logic               valid,
  input  logic [CLASS_W-1:0] clsRaw,
  input  logic               enable,
  input  pipeMask_t          freeMask,
  output pipeMask_t          grant,
  output logic               take
);
  // reservation work may only leave from the oldest slot
  localparam bit RESERVE_OK = (SLOT_IDX == 0);

  instClass_e cls;
  pipeMask_t  need;
  logic       flexible;
  logic       slotOk;

  always_comb begin
    cls      = instClass_e'(clsRaw);
    need     = '0;
    flexible = 1'b0;
    slotOk   = 1'b1;
    unique case (cls)
      CLS_SIMPLE:  flexible = 1'b1;
      CLS_MEM:     need[PIPE_L] = 1'b1;
      CLS_FLOAT:   need[PIPE_F] = 1'b1;
      CLS_RESERVE: begin
        need[PIPE_L] = 1'b1;
        need[PIPE_I] = 1'b1;
        slotOk       = RESERVE_OK;
      end
      CLS_SYNC: begin
        need[PIPE_I] = 1'b1;
        need[PIPE_L] = 1'b1;
        need[PIPE_F] = 1'b1;
      end
      default:     need[PIPE_I] = 1'b1;
    endcase
  end

  always_comb begin
    grant = '0;
    take  = 1'b0;
    if (valid && enable && slotOk) begin
      if (flexible) begin
        if (freeMask[PIPE_I]) begin
          grant[PIPE_I] = 1'b1;
          take          = 1'b1;
        end else if (freeMask[PIPE_J]) begin
          grant[PIPE_J] = 1'b1;
          take          = 1'b1;
        end
      end else if ((need & ~freeMask) == '0) begin
        grant = need;
        take  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               slot0Valid,
  input  logic [CLASS_W-1:0] slot0Class,
  input  logic               slot1Valid,
  input  logic [CLASS_W-1:0] slot1Class,
  input  pipeMask_t          pipeBusy,
  output steerStrobe_t       strobe,
  output logic               slot0Ready,
  output logic               slot1Ready,
  output logic               stall
);
  logic               slotValid [SLOT_CNT];
  logic [CLASS_W-1:0] slotClass [SLOT_CNT];
  pipeMask_t          slotFree  [SLOT_CNT];
  pipeMask_t          slotGrant [SLOT_CNT];
  logic               slotEn    [SLOT_CNT];
  logic               slotTake  [SLOT_CNT];

  assign slotValid[0] = slot0Valid;
  assign slotValid[1] = slot1Valid;
  assign slotClass[0] = slot0Class;
  assign slotClass[1] = slot1Class;

  // older slot sees every idle pipe; younger sees what is left and
  // only gets a turn once the older one has gone
  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    if (s == 0) begin : g_head
      assign slotFree[s] = ~pipeBusy;
      assign slotEn[s]   = 1'b1;
    end else begin : g_tail
      assign slotFree[s] = slotFree[s-1] & ~slotGrant[s-1];
      assign slotEn[s]   = slotTake[s-1];
    end
    steer_pick #(.SLOT_IDX(s)) i_pick (
      .valid   (slotValid[s]),
      .clsRaw  (slotClass[s]),
      .enable  (slotEn[s]),
      .freeMask(slotFree[s]),
      .grant   (slotGrant[s]),
      .take    (slotTake[s])
    );
  end

  always_comb begin
    strobe.grant0 = slotGrant[0];
    strobe.grant1 = slotGrant[1];
    strobe.take0  = slotTake[0];
    strobe.take1  = slotTake[1];
  end

  assign slot0Ready = slotTake[0];
  assign slot1Ready = slotTake[1];
  assign stall      = (slot0Valid & ~slotTake[0]) | (slot1Valid & ~slotTake[1]);

  p_one_owner_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe.grant0 & strobe.grant1) == '0);

  p_in_order_r8: assert property (@(posedge clk) disable iff (rst)
    slot1Ready |-> (slot0Valid && slot0Ready));

  p_busy_kept_r9: assert property (@(posedge clk) disable iff (rst)
    ((strobe.grant0 | strobe.grant1) & pipeBusy) == '0);

  p_reserve_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (slot1Ready && slot1Class == CLS_RESERVE) |-> 1'b0);

  p_reserve_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (slot0Ready && slot0Class == CLS_RESERVE) |->
      (strobe.grant0[PIPE_I] && strobe.grant0[PIPE_L]));

  p_sync_all_r6: assert property (@(posedge clk) disable iff (rst)
    (slot0Ready && slot0Class == CLS_SYNC) |->
      (strobe.grant0[PIPE_I] && strobe.grant0[PIPE_L] && strobe.grant0[PIPE_F]));

  p_taken_has_pipe_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe.grant1) <= 1);
endmodule

// File: rtl/steer_lanes.sv
module steer_lanes
  import steer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  steerStrobe_t               strobe,
  input  logic [DATA_W-1:0]          slot0Data,
  input  logic [DATA_W-1:0]          slot1Data,
  output pipeMask_t                  dispValid,
  output pipeMask_t                  dispSlot,
  output logic [PIPE_CNT*DATA_W-1:0] laneData
);
  for (genvar p = 0; p < PIPE_CNT; p++) begin : g_lane
    logic [DATA_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        dispValid[p] <= 1'b0;
        dispSlot[p]  <= 1'b0;
        laneQ        <= '0;
      end else begin
        dispValid[p] <= strobe.grant0[p] | strobe.grant1[p];
        dispSlot[p]  <= strobe.grant1[p];
        if (strobe.grant1[p])      laneQ <= slot1Data;
        else if (strobe.grant0[p]) laneQ <= slot0Data;
        else                       laneQ <= '0;
      end
    end
    assign laneData[p*DATA_W +: DATA_W] = laneQ;
  end

  p_follow_grant_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dispValid == $past(strobe.grant0 | strobe.grant1));

  p_slot_implies_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (dispSlot & ~dispValid) == '0);
endmodule

// File: rtl/steer_unit.sv
module steer_unit
  import steer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       slot0Valid,
  input  logic [CLASS_W-1:0]         slot0Class,
  input  logic [DATA_W-1:0]          slot0Data,
  input  logic                       slot1Valid,
  input  logic [CLASS_W-1:0]         slot1Class,
  input  logic [DATA_W-1:0]          slot1Data,
  input  logic [PIPE_CNT-1:0]        pipeBusy,
  output logic                       slot0Ready,
  output logic                       slot1Ready,
  output logic                       stall,
  output logic [PIPE_CNT-1:0]        dispValid,
  output logic [PIPE_CNT-1:0]        dispSlot,
  output logic [PIPE_CNT*DATA_W-1:0] laneData
);
  steerStrobe_t strobe;

  steer_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .slot0Valid(slot0Valid),
    .slot0Class(slot0Class),
    .slot1Valid(slot1Valid),
    .slot1Class(slot1Class),
    .pipeBusy  (pipeBusy),
    .strobe    (strobe),
    .slot0Ready(slot0Ready),
    .slot1Ready(slot1Ready),
    .stall     (stall)
  );

  steer_lanes #(.DATA_W(DATA_W)) i_lanes (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .slot0Data(slot0Data),
    .slot1Data(slot1Data),
    .dispValid(dispValid),
    .dispSlot (dispSlot),
    .laneData (laneData)
  );
endmodule

// File: tb/test_steer_unit.sv
module test_steer_unit;
  localparam int DW  = 16;
  localparam int NV  = 21;
  localparam int NP  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slot0Valid = 1'b0, slot1Valid = 1'b0;
  logic [2:0]    slot0Class = '0, slot1Class = '0;
  logic [DW-1:0] slot0Data = '0, slot1Data = '0;
  logic [3:0]    pipeBusy = '0;
  logic          slot0Ready, slot1Ready, stall;
  logic [3:0]    dispValid, dispSlot;
  logic [NP*DW-1:0] laneData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  steer_unit #(.DATA_W(DW)) i_steer_unit (
    .clk(clk), .rst(rst),
    .slot0Valid(slot0Valid), .slot0Class(slot0Class), .slot0Data(slot0Data),
    .slot1Valid(slot1Valid), .slot1Class(slot1Class), .slot1Data(slot1Data),
    .pipeBusy(pipeBusy), .slot0Ready(slot0Ready), .slot1Ready(slot1Ready),
    .stall(stall), .dispValid(dispValid), .dispSlot(dispSlot), .laneData(laneData)
  );

  // {req, s0v, s0c, s1v, s1c, busy(F L J I), rdy0, rdy1, valid(F L J I), src(F L J I)}
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  1'b1,3'd0, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R2 both simple
    {4'd3,  1'b1,3'd1, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R3 complex + simple
    {4'd7,  1'b1,3'd0, 1'b1,3'd1, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R7 simple took I
    {4'd4,  1'b1,3'd2, 1'b1,3'd3, 4'b0000, 1'b1,1'b1, 4'b1100, 4'b1000}, // R4 mem + float
    {4'd7,  1'b1,3'd2, 1'b1,3'd2, 4'b0000, 1'b1,1'b0, 4'b0100, 4'b0000}, // R7 two mem
    {4'd7,  1'b1,3'd3, 1'b1,3'd3, 4'b0000, 1'b1,1'b0, 4'b1000, 4'b0000}, // R7 two float
    {4'd5,  1'b1,3'd4, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0111, 4'b0010}, // R5 reserve + simple
    {4'd5,  1'b1,3'd0, 1'b1,3'd4, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R5 reserve in slot 1
    {4'd6,  1'b1,3'd5, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b1111, 4'b0010}, // R6 sync + simple
    {4'd6,  1'b1,3'd5, 1'b1,3'd3, 4'b0000, 1'b1,1'b0, 4'b1101, 4'b0000}, // R6 sync + float
    {4'd9,  1'b1,3'd0, 1'b1,3'd0, 4'b0001, 1'b1,1'b0, 4'b0010, 4'b0000}, // R9 I busy
    {4'd9,  1'b1,3'd0, 1'b1,3'd0, 4'b0010, 1'b1,1'b0, 4'b0001, 4'b0000}, // R9 J busy
    {4'd8,  1'b1,3'd1, 1'b1,3'd2, 4'b0001, 1'b0,1'b0, 4'b0000, 4'b0000}, // R8 slot 0 blocked
    {4'd8,  1'b0,3'd0, 1'b1,3'd2, 4'b0000, 1'b0,1'b0, 4'b0000, 4'b0000}, // R8 slot 0 empty
    {4'd9,  1'b1,3'd4, 1'b1,3'd0, 4'b0100, 1'b0,1'b0, 4'b0000, 4'b0000}, // R9 reserve, L busy
    {4'd3,  1'b1,3'd6, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R3 code 6
    {4'd9,  1'b1,3'd2, 1'b1,3'd0, 4'b1000, 1'b1,1'b1, 4'b0101, 4'b0001}, // R9 F busy
    {4'd12, 1'b0,3'd0, 1'b0,3'd0, 4'b0000, 1'b0,1'b0, 4'b0000, 4'b0000}, // R12 idle
    {4'd3,  1'b1,3'd7, 1'b1,3'd1, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R3 code 7 vs complex
    {4'd6,  1'b1,3'd5, 1'b1,3'd0, 4'b0010, 1'b1,1'b0, 4'b1101, 4'b0000}, // R6 sync, J busy
    {4'd4,  1'b1,3'd3, 1'b1,3'd2, 4'b0000, 1'b1,1'b1, 4'b1100, 4'b0100}  // R4 float + mem
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v0, input logic [2:0] c0, input logic [DW-1:0] d0,
                       input logic v1, input logic [2:0] c1, input logic [DW-1:0] d1,
                       input logic [3:0] busy);
    slot0Valid = v0; slot0Class = c0; slot0Data = d0;
    slot1Valid = v1; slot1Class = c1; slot1Data = d1;
    pipeBusy = busy;
  endtask

  function automatic logic [NP*DW-1:0] lanes(input logic [3:0] val, input logic [3:0] src,
                                             input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    logic [NP*DW-1:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (val[p]) r[p*DW +: DW] = src[p] ? d1 : d0;
    return r;
  endfunction

  initial begin
    #(8*20000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    string tag;
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", "valid after reset", dispValid, 4'b0000);
    check("R11", "lanes after reset", laneData, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      logic [DW-1:0] d0, d1;
      logic expStall;
      v = VEC[i];
      d0 = DW'(16'hA000 + i);
      d1 = DW'(16'hB000 + i);
      tag = $sformatf("R%0d#%0d", v[25:22], i);
      @(negedge clk);
      drive(v[21], v[20:18], d0, v[17], v[16:14], d1, v[13:10]);
      #1;
      expStall = (v[21] & ~v[9]) | (v[17] & ~v[8]);
      check(tag, "slot0Ready", slot0Ready, v[9]);
      check(tag, "slot1Ready", slot1Ready, v[8]);
      check(tag, "stall R12", stall, expStall);
      @(posedge clk); #1;
      check(tag, "dispValid R10", dispValid, v[7:4]);
      check(tag, "dispSlot R10", dispSlot, v[3:0]);
      check(tag, "laneData R10", laneData, lanes(v[7:4], v[3:0], d0, d1));
    end

    // R7/R8: refused slot-1 complex op dispatches once it reaches slot 0
    @(negedge clk);
    drive(1'b1, 3'd0, 16'h1111, 1'b1, 3'd1, 16'h2222, 4'b0000);
    #1 check("R7", "younger refused", slot1Ready, 1'b0);
    @(negedge clk);
    drive(1'b1, 3'd1, 16'h2222, 1'b0, 3'd0, 16'h0, 4'b0000);
    #1 check("R8", "advanced slot taken", slot0Ready, 1'b1);
    @(posedge clk); #1;
    check("R3", "advanced op on I", dispValid, 4'b0001);
    check("R10", "advanced payload", laneData, lanes(4'b0001, 4'b0000, 16'h2222, 16'h0));

    // R11: reset while traffic is present
    @(negedge clk);
    drive(1'b1, 3'd5, 16'h3333, 1'b1, 3'd0, 16'h4444, 4'b0000);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11", "valid under reset", dispValid, 4'b0000);
    check("R11", "slot under reset", dispSlot, 4'b0000);
    check("R11", "lanes under reset", laneData, '0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0, 4'b0000);
    @(posedge clk); #1;
    check("R1", "idle after reset", dispValid, 4'b0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule